// File: doc/BRIEF.md
# Serial Control Port with Round-Robin Event Reporting

This block is a byte-wide synchronous serial slave through which a host processor controls a line interface device. Each access is framed by an active-low select. While it is low, the host clocks eight bits of a command in on the serial data input. At the same time the block shifts one status byte out, most significant bit first. When the select rises after exactly eight rising serial clocks, the command byte is handed to a command decoder with a one-cycle strobe. What the decoder does with the byte is outside this block.

Status is event driven. Each event source has its own latch, which holds a flag and a small data field until the host reads it out. When several events are pending, each read reports one of them, taken in circular order from where the last read stopped. There is no priority between sources. An active-low interrupt output with a separate output enable tells the host to read. The enable turns on when an event arrives while the select is high, or when the select rises with events still pending. It turns off at the first rising serial clock of an access. One source is the device-reset event, which discards everything else that is pending. Because every status read also loads a command, the host sends 0xFF as a no-operation when it only wants status; the decoder gives that value its meaning.

The serial pins are sampled in the core clock domain and are assumed to be already synchronous to it. The serial clock must be at least four core clocks per half period.

Top module: `mwire_ctrl_port`

## Requirements
- R1: Bits on `sdi` are captured on rising `sclk` edges while `cs_n` is low, first bit as the most significant. On the rise of `cs_n`, if exactly 8 rising edges were seen, `cmd_byte` takes the byte and `cmd_stb` is high for one `clk` cycle. Any other count leaves both unchanged.
- R2: The status byte is frozen when `cs_n` falls and appears on `sdo` MSB first. Each falling `sclk` edge that follows at least one rising edge moves `sdo` to the next bit. Layout: bit 7 = something reported, bits 6:4 = source index, bits 3:0 = that source's data. The byte is 0x00 when nothing is pending.
- R3: A one-cycle pulse on `evt_vld[i]` marks source i pending and stores `evt_dat[4i+3:4i]`. A later pulse on the same unread source replaces the stored data.
- R4: The reported source is the first pending index at or above an internal pointer, wrapping from 5 to 0. After a complete transfer that reported a source, the pointer moves to one past that source. The pointer starts at 0.
- R5: A complete 8-bit transfer clears the latch of the source it reported when `cs_n` rises. A transfer of any other length clears nothing and leaves the pointer where it is.
- R6: A pulse on `evt_vld[0]` (the device-reset source) clears every other pending source and marks source 0 pending with its data. Other pulses in the same cycle are dropped.
- R7: If the source being reported receives a new event during its own transfer, it stays pending with the new data after `cs_n` rises.
- R8: `irq_oe` goes high one `clk` cycle after an event pulse while `cs_n` is high, and `irq_n` is low exactly while `irq_oe` is high. Both are inactive after reset.
- R9: `irq_oe` goes low on the first rising `sclk` while `cs_n` is low. Events that arrive while `cs_n` is low do not raise it.
- R10: When `cs_n` rises and any source is still pending, `irq_oe` goes high again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transfer select |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial status output |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | Interrupt pin drive enable |
| evt_vld | input | NSRC | Per-source event pulses |
| evt_dat | input | NSRC*DW | Per-source event data, DW bits each |
| cmd_byte | output | 8 | Last complete command byte |
| cmd_stb | output | 1 | One-cycle strobe for a new command byte |

## Verification
The hardest case to reach is an event landing in the middle of a transfer. That event must not raise the interrupt and must not be lost. When it hits the very source being reported, it must survive the clear at the end of the transfer. The transfer task can inject a pulse between the fourth and fifth serial bits, on either a different source or the source being reported. It checks the interrupt enable right there and checks the follow-up read afterwards. Pointer wrap-around and aborted five-bit transfers are reached by ordering event pulses so that the pending set lies behind the pointer.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

  // Circular successor of an index in a ring of n entries.
  function automatic int wrap_next(input int cur, input int n);
    if (cur >= n - 1) return 0;
    return cur + 1;
  endfunction

  // Circular sum of base and offset in a ring of n entries (offset < n).
  function automatic int wrap_add(input int base, input int ofs, input int n);
    int s;
    s = base + ofs;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/mwc_serial_if.sv
module mwc_serial_if #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] stat_byte,
  output logic              sdo,
  output logic              cs_fall,
  output logic              cs_rise,
  output logic              xfer_done,
  output logic              sel_rise,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_stb
);

  localparam int CNT_W = $clog2(BYTE_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic              cs_q, ck_q;
  logic              ck_rise, ck_fall;
  logic [BYTE_W-1:0] sh_in_q, sh_in_d;
  logic [BYTE_W-1:0] sh_out_q, sh_out_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              stb_q, stb_d;

  assign cs_fall   = cs_q & ~cs_n;
  assign cs_rise   = ~cs_q & cs_n;
  assign ck_rise   = sclk & ~ck_q;
  assign ck_fall   = ~sclk & ck_q;
  assign sel_rise  = ~cs_n & ck_rise;
  assign xfer_done = cs_rise & (cnt_q == CNT_FULL);

  always_comb begin
    sh_in_d  = sh_in_q;
    sh_out_d = sh_out_q;
    cnt_d    = cnt_q;
    if (cs_fall) begin
      sh_out_d = stat_byte;
      cnt_d    = '0;
    end else if (~cs_n) begin
      if (ck_rise) begin
        sh_in_d = {sh_in_q[BYTE_W-2:0], sdi};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      if (ck_fall && (cnt_q != '0)) begin
        sh_out_d = {sh_out_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    stb_d = xfer_done;
    cmd_d = xfer_done ? sh_in_q : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      ck_q     <= 1'b0;
      sh_in_q  <= '0;
      sh_out_q <= '0;
      cnt_q    <= '0;
      cmd_q    <= '0;
      stb_q    <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      ck_q     <= sclk;
      sh_in_q  <= sh_in_d;
      sh_out_q <= sh_out_d;
      cnt_q    <= cnt_d;
      cmd_q    <= cmd_d;
      stb_q    <= stb_d;
    end
  end

  assign sdo      = sh_out_q[BYTE_W-1];
  assign cmd_byte = cmd_q;
  assign cmd_stb  = stb_q;

  // R1
  stb_after_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> ($past(cs_n) && !$past(cs_q)));

  // R1
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |-> $stable(cmd_byte));

  // R2
  sdo_hold_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cs_n) && $past(!cs_q) && $past(sclk == ck_q)) |-> $stable(sdo));

endmodule

// File: rtl/mwc_event_bank.sv
module mwc_event_bank #(
  parameter int NSRC    = 6,
  parameter int DW      = 4,
  parameter int RST_IDX = 0,
  parameter int IDX_W   = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    evt_vld,
  input  logic [NSRC*DW-1:0] evt_dat,
  input  logic               cap,
  input  logic [IDX_W-1:0]   cap_idx,
  input  logic               cap_vld,
  input  logic               done,
  output logic [NSRC-1:0]    pend,
  output logic [NSRC*DW-1:0] dat,
  output logic [IDX_W-1:0]   ptr,
  output logic               pend_any_nx,
  output logic               evt_any
);

  logic [NSRC-1:0]    pend_q, pend_d;
  logic [NSRC*DW-1:0] dat_q, dat_d;
  logic [IDX_W-1:0]   hold_idx_q, hold_idx_d;
  logic               hold_vld_q, hold_vld_d;
  logic               retrig_q, retrig_d;
  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic               rst_evt;
  logic               rd_clr;

  assign rst_evt = evt_vld[RST_IDX];
  assign rd_clr  = done & hold_vld_q & ~retrig_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic set_g, clr_g;
    if (g == RST_IDX) begin : g_rst
      assign set_g = evt_vld[g];
      assign clr_g = rd_clr & (hold_idx_q == IDX_W'(g));
    end else begin : g_norm
      assign set_g = evt_vld[g] & ~rst_evt;
      assign clr_g = rst_evt | (rd_clr & (hold_idx_q == IDX_W'(g)));
    end
    assign pend_d[g]          = set_g | (pend_q[g] & ~clr_g);
    assign dat_d[g*DW +: DW]  = set_g ? evt_dat[g*DW +: DW] : dat_q[g*DW +: DW];

    // R3
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld[g] && !evt_vld[RST_IDX]) |=> (pend_q[g] && (dat_q[g*DW +: DW] == $past(evt_dat[g*DW +: DW]))));
  end

  always_comb begin
    hold_idx_d = hold_idx_q;
    hold_vld_d = hold_vld_q;
    retrig_d   = retrig_q;
    ptr_d      = ptr_q;
    if (cap) begin
      hold_idx_d = cap_idx;
      hold_vld_d = cap_vld;
      retrig_d   = 1'b0;
    end else if (evt_vld[hold_idx_q]) begin
      retrig_d   = 1'b1;
    end
    if (done && hold_vld_q) begin
      ptr_d = IDX_W'(mwc_pkg::wrap_next(int'(hold_idx_q), NSRC));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      dat_q      <= '0;
      hold_idx_q <= '0;
      hold_vld_q <= 1'b0;
      retrig_q   <= 1'b0;
      ptr_q      <= '0;
    end else begin
      pend_q     <= pend_d;
      dat_q      <= dat_d;
      hold_idx_q <= hold_idx_d;
      hold_vld_q <= hold_vld_d;
      retrig_q   <= retrig_d;
      ptr_q      <= ptr_d;
    end
  end

  assign pend        = pend_q;
  assign dat         = dat_q;
  assign ptr         = ptr_q;
  assign pend_any_nx = |pend_d;
  assign evt_any     = |evt_vld;

  // R6
  reset_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld[RST_IDX] |=> (pend_q == (NSRC'(1) << RST_IDX)));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hold_vld_q && !retrig_q && !(|evt_vld)) |=> !pend_q[$past(hold_idx_q)]);

  // R5
  abort_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(ptr_q));

endmodule

// File: rtl/mwc_rr_pick.sv
module mwc_rr_pick #(
  parameter int NSRC  = 6,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);

  // Walk the ring from the far end back to the pointer so that the
  // nearest pending entry is the last one written.
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (pend[mwc_pkg::wrap_add(int'(ptr), k, NSRC)]) begin
        vld = 1'b1;
        idx = IDX_W'(mwc_pkg::wrap_add(int'(ptr), k, NSRC));
      end
    end
  end

  // R4
  pick_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == (pend != '0)) && (!vld || pend[idx]));

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NSRC);

  // R4
  pick_at_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend[ptr] |-> (idx == ptr));

endmodule

// File: rtl/mwc_irq_ctl.sv
module mwc_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sel_rise,
  input  logic cs_rise,
  input  logic evt_any,
  input  logic pend_any_nx,
  output logic irq_oe
);

  logic oe_q, oe_d;
  logic set_en;

  assign set_en = cs_n & pend_any_nx & (evt_any | cs_rise);

  always_comb begin
    oe_d = oe_q;
    if (sel_rise) oe_d = 1'b0;
    if (set_en)   oe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  assign irq_oe = oe_q;

  // R9
  rise_only_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> $past(cs_n));

  // R9
  fall_on_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_oe) |-> $past(sel_rise));

  // R10
  reraise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && pend_any_nx) |=> irq_oe);

endmodule

// File: rtl/mwire_ctrl_port.sv
module mwire_ctrl_port #(
  parameter int NSRC    = 6,
  parameter int DW      = 4,
  parameter int RST_IDX = 0,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  output logic               irq_n,
  output logic               irq_oe,
  input  logic [NSRC-1:0]    evt_vld,
  input  logic [NSRC*DW-1:0] evt_dat,
  output logic [BYTE_W-1:0]  cmd_byte,
  output logic               cmd_stb
);

  localparam int IDX_W = $clog2(NSRC);

  logic              rst_s1_q, rst_s2_q;
  logic              rstn_i;
  logic              cs_fall, cs_rise, xfer_done, sel_rise;
  logic [NSRC-1:0]    pend;
  logic [NSRC*DW-1:0] dat;
  logic [IDX_W-1:0]   ptr, pick_idx;
  logic               pick_vld;
  logic               pend_any_nx, evt_any;
  logic [BYTE_W-1:0]  stat;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rstn_i = rst_s2_q;

  mwc_rr_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .clk  (clk),
    .rst_n(rstn_i),
    .pend (pend),
    .ptr  (ptr),
    .idx  (pick_idx),
    .vld  (pick_vld)
  );

  always_comb begin
    stat = '0;
    if (pick_vld) begin
      stat[BYTE_W-1]           = 1'b1;
      stat[BYTE_W-2 -: IDX_W]  = pick_idx;
      stat[DW-1:0]             = dat[pick_idx*DW +: DW];
    end
  end

  mwc_serial_if #(.BYTE_W(BYTE_W)) u_ser (
    .clk      (clk),
    .rst_n    (rstn_i),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdi      (sdi),
    .stat_byte(stat),
    .sdo      (sdo),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .xfer_done(xfer_done),
    .sel_rise (sel_rise),
    .cmd_byte (cmd_byte),
    .cmd_stb  (cmd_stb)
  );

  mwc_event_bank #(.NSRC(NSRC), .DW(DW), .RST_IDX(RST_IDX), .IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .rst_n      (rstn_i),
    .evt_vld    (evt_vld),
    .evt_dat    (evt_dat),
    .cap        (cs_fall),
    .cap_idx    (pick_idx),
    .cap_vld    (pick_vld),
    .done       (xfer_done),
    .pend       (pend),
    .dat        (dat),
    .ptr        (ptr),
    .pend_any_nx(pend_any_nx),
    .evt_any    (evt_any)
  );

  mwc_irq_ctl u_irq (
    .clk        (clk),
    .rst_n      (rstn_i),
    .cs_n       (cs_n),
    .sel_rise   (sel_rise),
    .cs_rise    (cs_rise),
    .evt_any    (evt_any),
    .pend_any_nx(pend_any_nx),
    .irq_oe     (irq_oe)
  );

  assign irq_n = ~irq_oe;

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    irq_n != irq_oe);

endmodule

// File: tb/sim_mwire_ctrl_port.sv
module sim_mwire_ctrl_port;

  localparam int NSRC = 6;
  localparam int DW   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_n, sclk, sdi;
  logic              sdo, irq_n, irq_oe, cmd_stb;
  logic [NSRC-1:0]    evt_vld;
  logic [NSRC*DW-1:0] evt_dat;
  logic [7:0]         cmd_byte;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;
  bit fin    = 0;
  int stb_seen = 0;

  always #2 clk = ~clk;

  mwire_ctrl_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .irq_n(irq_n), .irq_oe(irq_oe),
    .evt_vld(evt_vld), .evt_dat(evt_dat),
    .cmd_byte(cmd_byte), .cmd_stb(cmd_stb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_pend[NSRC];
  int m_dat[NSRC];
  int m_ptr, m_cnt, m_shin, m_shout, m_cmd, m_hold;
  bit m_hv, m_rt, m_irq, m_stb, m_pcs, m_pck, m_cslow;

  function automatic int m_status(output int src, output bit hit);
    hit = 0; src = 0;
    for (int k = 0; k < NSRC; k++) begin
      int p = (m_ptr + k) % NSRC;
      if (!hit && m_pend[p]) begin hit = 1; src = p; end
    end
    return hit ? (128 + src * 16 + m_dat[src]) : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin m_pend[i] = 0; m_dat[i] = 0; end
      m_ptr = 0; m_cnt = 0; m_shin = 0; m_shout = 0; m_cmd = 0; m_hold = 0;
      m_hv = 0; m_rt = 0; m_irq = 0; m_stb = 0; m_pcs = 1; m_pck = 0; m_cslow = 0;
    end else begin
      bit csf, csr, ckr, ckf, done, ohv, ort, any, eany;
      int ohold, src;
      bit hit;
      csf = m_pcs && !cs_n;  csr = !m_pcs && cs_n;
      ckr = sclk && !m_pck;  ckf = !sclk && m_pck;
      ohold = m_hold; ohv = m_hv; ort = m_rt;
      done = csr && (m_cnt == 8);
      m_stb = 0;
      if (!cs_n && ckr) m_irq = 0;
      if (csf) begin
        m_shout = m_status(src, hit);
        m_hold = src; m_hv = hit; m_rt = 0; m_cnt = 0;
      end else begin
        if (!cs_n) begin
          if (ckr) begin m_shin = ((m_shin << 1) | int'(sdi)) & 255; m_cnt++; end
          if (ckf && m_cnt > 0) m_shout = (m_shout << 1) & 255;
        end
        if (evt_vld[ohold]) m_rt = 1;
      end
      if (done) begin
        m_stb = 1; m_cmd = m_shin;
        if (ohv) m_ptr = (ohold + 1) % NSRC;
      end
      eany = |evt_vld;
      if (evt_vld[0]) begin
        for (int i = 0; i < NSRC; i++) m_pend[i] = 0;
        m_pend[0] = 1; m_dat[0] = int'(evt_dat[3:0]);
      end else begin
        if (done && ohv && !ort) m_pend[ohold] = 0;
        for (int i = 1; i < NSRC; i++)
          if (evt_vld[i]) begin m_pend[i] = 1; m_dat[i] = int'(evt_dat[i*DW +: DW]); end
      end
      any = 0;
      for (int i = 0; i < NSRC; i++) any |= m_pend[i];
      if (cs_n && any && (eany || csr)) m_irq = 1;
      m_pcs = cs_n; m_pck = sclk; m_cslow = !cs_n;
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8/R9/R10 irq_oe per-cycle", int'(irq_oe), int'(m_irq));
      chk("R8 irq_n per-cycle", int'(irq_n), int'(!m_irq));
      chk("R1 cmd_stb per-cycle", int'(cmd_stb), int'(m_stb));
      if (m_stb) chk("R1 cmd_byte per-cycle", int'(cmd_byte), m_cmd);
      if (m_cslow) chk("R2 sdo per-cycle", int'(sdo), (m_shout >> 7) & 1);
    end
  end

  always @(posedge clk) if (cmd_stb) stb_seen++;

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int src, input int d);
    evt_vld[src] = 1'b1;
    evt_dat[src*DW +: DW] = 4'(d);
    tick(1);
    evt_vld = '0;
    tick(2);
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nbits,
                      input int ev_src, input int ev_dat, output logic [7:0] got);
    got = 8'h00;
    cs_n = 1'b0;
    tick(2);
    for (int b = 0; b < nbits; b++) begin
      sdi = cmd[7-b];
      tick(2);
      got[7-b] = sdo;
      if (b == 3 && ev_src >= 0) begin
        evt_vld[ev_src] = 1'b1;
        evt_dat[ev_src*DW +: DW] = 4'(ev_dat);
        tick(1);
        evt_vld = '0;
        tick(1);
        chk("R9 no interrupt while selected", int'(irq_oe), 0);
      end
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(2);
    end
    tick(1);
    cs_n = 1'b1;
    tick(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int s0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    evt_vld = '0; evt_dat = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    cmp_on = 1;

    // reset state (R8)
    chk("R8 irq_oe after reset", int'(irq_oe), 0);
    chk("R8 irq_n after reset", int'(irq_n), 1);
    chk("R1 cmd_stb after reset", int'(cmd_stb), 0);

    // empty read, command capture (R1, R2)
    xfer(8'h3C, 8, -1, 0, got);
    chk("R2 empty status", int'(got), 8'h00);
    chk("R1 command byte", int'(cmd_byte), 8'h3C);

    // single event (R3, R8, R9)
    pulse(2, 5);
    chk("R8 interrupt on event", int'(irq_oe), 1);
    xfer(8'hFF, 8, -1, 0, got);
    chk("R3 status of source 2", int'(got), 8'hA5);
    chk("R9 interrupt cleared by transfer", int'(irq_oe), 0);

    // round robin, overwrite, wrap (R3, R4, R10)
    pulse(1, 3); pulse(4, 9); pulse(1, 7);
    xfer(8'hFF, 8, -1, 0, got);
    chk("R4 first at or after pointer", int'(got), 8'hC9);
    chk("R10 re-raise with pending", int'(irq_oe), 1);
    xfer(8'hFF, 8, -1, 0, got);
    chk("R4 wrap and R3 overwrite", int'(got), 8'h97);
    chk("R10 no re-raise when empty", int'(irq_oe), 0);
    xfer(8'hFF, 8, -1, 0, got);
    chk("R5 latches cleared after reads", int'(got), 8'h00);

    // aborted transfer (R1, R5)
    pulse(3, 1);
    s0 = stb_seen;
    xfer(8'h55, 5, -1, 0, got);
    chk("R1 no strobe on short transfer", stb_seen - s0, 0);
    chk("R10 re-raise after short transfer", int'(irq_oe), 1);
    xfer(8'hFF, 8, -1, 0, got);
    chk("R5 short transfer kept latch", int'(got), 8'hB1);

    // event on another source mid-transfer (R9, R10)
    pulse(5, 2);
    xfer(8'hFF, 8, 1, 6, got);
    chk("R2 status of source 5", int'(got), 8'hD2);
    chk("R10 re-raise for mid-transfer event", int'(irq_oe), 1);
    xfer(8'hFF, 8, -1, 0, got);
    chk("R4 mid-transfer event read next", int'(got), 8'h96);

    // event on the reported source mid-transfer (R7)
    pulse(2, 4);
    xfer(8'hFF, 8, 2, 8, got);
    chk("R7 reported old data", int'(got), 8'hA4);
    chk("R7 still pending interrupt", int'(irq_oe), 1);
    xfer(8'hFF, 8, -1, 0, got);
    chk("R7 new data survives", int'(got), 8'hA8);

    // reset event (R6)
    pulse(1, 1); pulse(2, 2); pulse(5, 5);
    evt_vld = 6'b001001;
    evt_dat = '0;
    evt_dat[3:0] = 4'hE;
    evt_dat[15:12] = 4'h7;
    tick(1);
    evt_vld = '0;
    tick(2);
    xfer(8'hFF, 8, -1, 0, got);
    chk("R6 only reset source reported", int'(got), 8'h8E);
    xfer(8'hFF, 8, -1, 0, got);
    chk("R6 others discarded", int'(got), 8'h00);

    // no-operation byte is forwarded like any other (R1)
    s0 = stb_seen;
    xfer(8'hFF, 8, -1, 0, got);
    chk("R1 strobe for 0xFF", stb_seen - s0, 1);
    chk("R1 command 0xFF", int'(cmd_byte), 8'hFF);

    fin = 1;
    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule